// File: doc/BRIEF.md
# Branch Condition Evaluator

A combinational unit that decides whether a conditional branch in a processor core is taken. It accepts two register operands and a 3-bit condition code. It forms one difference, a minus b, using a single adder that computes a + ~b + 1. From that difference it derives four flags: zero, borrow, sign and signed overflow. The equality, signed-ordering and unsigned-ordering conditions are all read from those flags, so no separate comparators are needed.

Signed ordering does not use the sign bit of the difference alone. When the subtraction overflows, the sign bit gives the wrong answer. The signed less-than result is therefore the sign bit XORed with the overflow flag. The overflow flag is the XOR of the carry into the top bit and the carry out of it. A parameter selects a second way to form signed less-than: both operands are extended by one sign bit and subtracted, and the extra top bit of that difference is the answer. The flags and the signed less-than result are also brought out, so the core can use them for other purposes.

Target address arithmetic, program counter update and pipeline flush belong to the surrounding core.

Top module: `br_cond_eval`

## Requirements
- R1: zero_o is 1 exactly when a_i equals b_i.
- R2: borrow_o is 1 exactly when a_i is less than b_i as unsigned numbers. For example, 1 minus 2 gives borrow_o=1, and 2 minus 1 gives borrow_o=0.
- R3: overflow_o is 1 exactly when a_i minus b_i, taken as two's-complement numbers, lies outside the signed range of WIDTH bits.
- R4: sign_o equals the most significant bit of (a_i - b_i) mod 2^WIDTH.
- R5: signed_lt_o is 1 exactly when a_i is less than b_i as two's-complement numbers. This includes the case where the subtraction overflows: the most negative value compared with the most positive value gives signed_lt_o=1.
- R6: For funct_i=3'b000 (equal), taken_o equals zero_o. For funct_i=3'b001 (not equal), taken_o equals the inverse of zero_o.
- R7: For funct_i=3'b100 (signed less-than), taken_o is 1 when signed a_i < b_i. For funct_i=3'b101 (signed greater-or-equal), taken_o is 1 when signed a_i >= b_i.
- R8: For funct_i=3'b110 (unsigned less-than), taken_o is 1 when unsigned a_i < b_i. For funct_i=3'b111 (unsigned greater-or-equal), taken_o is 1 when unsigned a_i >= b_i.
- R9: For funct_i=3'b010 and funct_i=3'b011, taken_o is 0 for every pair of operands.
- R10: The outputs settle in the same cycle as the inputs change. There is no register between any input and any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | First operand (minuend) |
| b_i | input | WIDTH | Second operand (subtrahend) |
| funct_i | input | 3 | Condition code that selects the branch condition |
| taken_o | output | 1 | Branch decision |
| zero_o | output | 1 | Difference is all zeros |
| borrow_o | output | 1 | Subtraction produced a borrow (unsigned a < b) |
| sign_o | output | 1 | Top bit of the difference |
| overflow_o | output | 1 | Signed overflow of the subtraction |
| signed_lt_o | output | 1 | Signed a < b |

## Verification
The block has no state, so a fault in the carry chain or in a flag derivation shows on the ports in the same cycle as the operands that exercise it. The weak spots are the carry into the top bit and the sign-XOR-overflow path. Those faults appear only on operand pairs whose signs differ and whose subtraction overflows, such as the most negative value against the most positive value. Corner pairs of that kind are therefore applied under all eight condition codes, together with random operands and random equal operands.

// File: rtl/br_pkg.sv
package br_pkg;
  typedef enum logic [2:0] {
    BR_EQ  = 3'b000,
    BR_NE  = 3'b001,
    BR_LT  = 3'b100,
    BR_GE  = 3'b101,
    BR_LTU = 3'b110,
    BR_GEU = 3'b111
  } br_funct_e;

  typedef struct packed {
    logic zero;
    logic borrow;
    logic sign;
    logic overflow;
    logic slt;
  } br_flags_t;
endpackage

// File: rtl/br_sub.sv
module br_sub #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] diff_o,
  output logic             c_msb_o,
  output logic             c_out_o
);
  localparam int unsigned LW = WIDTH - 1;

  logic [WIDTH-1:0] low_sum;
  logic [1:0]       top_sum;

  // lower bits of a + ~b + 1; top bit of low_sum is the carry into the MSB
  assign low_sum = {1'b0, a_i[LW-1:0]} + {1'b0, ~b_i[LW-1:0]} + WIDTH'(1);
  assign top_sum = {1'b0, a_i[LW]} + {1'b0, ~b_i[LW]} + {1'b0, low_sum[LW]};

  assign diff_o  = {top_sum[0], low_sum[LW-1:0]};
  assign c_msb_o = low_sum[LW];
  assign c_out_o = top_sum[1];
endmodule

// File: rtl/br_flags.sv
module br_flags
  import br_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] diff_i,
  input  logic             c_msb_i,
  input  logic             c_out_i,
  input  logic             slt_i,
  output br_flags_t        flags_o
);
  always_comb begin
    flags_o.zero     = ~|diff_i;
    flags_o.borrow   = ~c_out_i;
    flags_o.sign     = diff_i[WIDTH-1];
    flags_o.overflow = c_msb_i ^ c_out_i;
    flags_o.slt      = slt_i;
  end
endmodule

// File: rtl/br_select.sv
module br_select
  import br_pkg::*;
(
  input  logic [2:0] funct_i,
  input  br_flags_t  flags_i,
  output logic       taken_o
);
  always_comb begin
    case (funct_i)
      BR_EQ:   taken_o = flags_i.zero;
      BR_NE:   taken_o = ~flags_i.zero;
      BR_LT:   taken_o = flags_i.slt;
      BR_GE:   taken_o = ~flags_i.slt;
      BR_LTU:  taken_o = flags_i.borrow;
      BR_GEU:  taken_o = ~flags_i.borrow;
      default: taken_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/br_cond_eval.sv
module br_cond_eval
  import br_pkg::*;
#(
  parameter int unsigned WIDTH    = 32,
  parameter bit          SLT_WIDE = 1'b0
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [2:0]       funct_i,
  output logic             taken_o,
  output logic             zero_o,
  output logic             borrow_o,
  output logic             sign_o,
  output logic             overflow_o,
  output logic             signed_lt_o
);
  logic [WIDTH-1:0] diff;
  logic             c_msb;
  logic             c_out;
  logic             slt;
  br_flags_t        flags;

  br_sub #(.WIDTH(WIDTH)) u_sub (
    .a_i    (a_i),
    .b_i    (b_i),
    .diff_o (diff),
    .c_msb_o(c_msb),
    .c_out_o(c_out)
  );

  generate
    if (SLT_WIDE) begin : g_slt_wide
      logic [WIDTH:0] ext_diff;
      assign ext_diff = {a_i[WIDTH-1], a_i} - {b_i[WIDTH-1], b_i};
      assign slt      = ext_diff[WIDTH];
    end else begin : g_slt_xor
      assign slt = diff[WIDTH-1] ^ (c_msb ^ c_out);
    end
  endgenerate

  br_flags #(.WIDTH(WIDTH)) u_flags (
    .diff_i (diff),
    .c_msb_i(c_msb),
    .c_out_i(c_out),
    .slt_i  (slt),
    .flags_o(flags)
  );

  br_select u_select (
    .funct_i(funct_i),
    .flags_i(flags),
    .taken_o(taken_o)
  );

  assign zero_o      = flags.zero;
  assign borrow_o    = flags.borrow;
  assign sign_o      = flags.sign;
  assign overflow_o  = flags.overflow;
  assign signed_lt_o = flags.slt;
endmodule

// File: rtl/br_cond_eval_chk.sv
module br_cond_eval_chk #(
  parameter int unsigned WIDTH = 32
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [2:0]       funct_i,
  input logic             taken_o,
  input logic             zero_o,
  input logic             borrow_o,
  input logic             sign_o,
  input logic             overflow_o,
  input logic             signed_lt_o
);
  always_comb begin
    a_r1_zero_eq: assert (zero_o == (a_i == b_i));
    a_r2_borrow_ult: assert (borrow_o == (a_i < b_i));
    a_r3_overflow: assert (overflow_o ==
      ((a_i[WIDTH-1] != b_i[WIDTH-1]) && (sign_o != a_i[WIDTH-1])));
    a_r5_signed_lt: assert (signed_lt_o == ($signed(a_i) < $signed(b_i)));
    a_r9_reserved_not_taken: assert (!(funct_i[2:1] == 2'b01) || !taken_o);
    a_r6_ne_taken: assert (!(funct_i == 3'b001) || (taken_o == (a_i != b_i)));
  end
endmodule

bind br_cond_eval br_cond_eval_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i        (a_i),
  .b_i        (b_i),
  .funct_i    (funct_i),
  .taken_o    (taken_o),
  .zero_o     (zero_o),
  .borrow_o   (borrow_o),
  .sign_o     (sign_o),
  .overflow_o (overflow_o),
  .signed_lt_o(signed_lt_o)
);

// File: tb/br_cond_eval_tb.sv
module br_cond_eval_tb;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic [W-1:0] a, b;
  logic [2:0]   funct;
  logic         taken, zero, borrow, sign, ovf, slt;
  int           n_cmp = 0;
  int           n_bad = 0;
  bit           done  = 1'b0;

  always #5 clk = ~clk;

  br_cond_eval #(.WIDTH(W)) u_dut (
    .a_i(a), .b_i(b), .funct_i(funct),
    .taken_o(taken), .zero_o(zero), .borrow_o(borrow),
    .sign_o(sign), .overflow_o(ovf), .signed_lt_o(slt)
  );

  task automatic cmp(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s a=%h b=%h f=%b actual=%b expected=%b", req, a, b, funct, act, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] av, input logic [W-1:0] bv, input logic [2:0] fv);
    longint sa, sb, sd;
    logic [W-1:0] d;
    logic e_zero, e_bor, e_sign, e_ovf, e_slt, e_take;
    @(posedge clk);
    a = av; b = bv; funct = fv;
    sa = longint'($signed(av));
    sb = longint'($signed(bv));
    sd = sa - sb;
    d  = av - bv;
    e_zero = (av == bv);
    e_bor  = (av < bv);
    e_sign = d[W-1];
    e_ovf  = (sd > 64'sd2147483647) || (sd < -64'sd2147483648);
    e_slt  = (sa < sb);
    case (fv)
      3'b000: e_take = e_zero;
      3'b001: e_take = !e_zero;
      3'b100: e_take = e_slt;
      3'b101: e_take = !e_slt;
      3'b110: e_take = e_bor;
      3'b111: e_take = !e_bor;
      default: e_take = 1'b0;
    endcase
    @(negedge clk);  // R10: outputs valid in the same cycle
    cmp("R1 zero", zero, e_zero);
    cmp("R2 borrow", borrow, e_bor);
    cmp("R3 overflow", ovf, e_ovf);
    cmp("R4 sign", sign, e_sign);
    cmp("R5 signed_lt", slt, e_slt);
    if (fv[2:1] == 2'b00)      cmp("R6 taken", taken, e_take);
    else if (fv[2:1] == 2'b10) cmp("R7 taken", taken, e_take);
    else if (fv[2:1] == 2'b11) cmp("R8 taken", taken, e_take);
    else                       cmp("R9 taken", taken, e_take);
  endtask

  logic [W-1:0] corners [10] = '{32'h0, 32'h1, 32'h2, 32'h7FFF_FFFF, 32'h8000_0000,
                                 32'hFFFF_FFFF, 32'h8000_0001, 32'h7FFF_FFFE,
                                 32'h0000_0080, 32'h0000_007F};

  initial begin
    a = '0; b = '0; funct = 3'b000;
    // corner pairs under every code, incl. 0x80000000 vs 0x7FFFFFFF (R5) and 1-2 (R2)
    for (int i = 0; i < 10; i++)
      for (int j = 0; j < 10; j++)
        for (int f = 0; f < 8; f++)
          apply(corners[i], corners[j], 3'(f));
    for (int k = 0; k < 3000; k++) begin
      logic [W-1:0] ra;
      ra = $urandom;
      apply(ra, (k % 5 == 0) ? ra : W'($urandom), 3'($urandom_range(7)));
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule